// File: doc/BRIEF.md
# Monotonic Time-of-Day Correction Governor

This block owns a time-of-day counter that advances by a fixed nominal increment on every clock once it has been seeded from a battery-backed clock value. Offsets produced by an external servo are submitted as correction requests. Each request carries a signed offset and a mode, either step or slew. The governor applies each request under rules that keep time moving forward. A positive step jumps the counter at once, but the jump is capped. Any part of the step beyond the cap, any slew request, and any negative step are worked off gradually. The governor does this by bending the per-cycle increment, and it never subtracts from the counter.

Each applied jump raises a marker strobe that carries the amount applied, so the discontinuity can be recorded. A negative step would have moved time backward. The governor converts it to slew and reports it through a flag and a saturating counter, which should stay at zero in healthy operation. Every log-worthy event stamps a sequence number that only ever counts up, so event order survives any correction. The events are seeding, an applied jump, a backward attempt and the end of a slew.

Requests enter over a valid/ready stream. Ready is high only after seeding and only while no offset is pending. The source must hold valid, mode and offset steady until the cycle in which both valid and ready are high. Exactly one request transfers in that cycle. The configuration inputs are plain levels and are expected to stay static while a correction is in progress.

Top module: `tod_governor`

## Requirements
- R1: After reset, tod is 0, tod_valid is 0, req_ready is 0, evt_seq is 0, and the marker, limit, rollback and event strobes are low.
- R2: A seed_valid pulse while unseeded loads tod with seed_tod at the next edge and sets tod_valid. From then on, tod grows by NOM_INC per cycle when no correction is active. Any later seed_valid is ignored.
- R3: Once seeded, tod never decreases. Each cycle it grows by at least max(cfg_min_inc, 1), provided cfg_min_inc does not exceed NOM_INC.
- R4: req_ready is high exactly when the block is seeded and slew_busy is low. A request held valid against low ready is not taken until ready rises.
- R5: req_mode 1 selects step. An accepted positive step no larger than cfg_max_jump makes tod grow by NOM_INC plus the offset at the accepting edge. In the following cycle, mark_valid pulses for one cycle with mark_amount equal to the offset.
- R6: A positive step above cfg_max_jump applies exactly cfg_max_jump as the jump. limit_hit pulses in the same cycle as mark_valid, and the remainder becomes pending slew.
- R7: req_mode 0 selects slew. While an offset is pending, each cycle adds a correction toward zero whose magnitude is the smallest of the pending amount, cfg_slew_delta and, for negative corrections, NOM_INC minus the floor. After slew_busy falls, the total advance equals elapsed cycles times NOM_INC plus the requested offset.
- R8: A negative step is never applied as a jump. It is slewed instead. rollback_flag pulses for one cycle, no marker is raised, and rollback_cnt increments, saturating at all ones.
- R9: evt_valid pulses once for each cycle that contains a seed load, an applied jump, a backward attempt or a slew completion. evt_seq increments by exactly one with each pulse, wraps modulo 2^SEQ_W, and is otherwise held.
- R10: A zero offset in either mode is accepted with no effect: no jump, no pending slew, no strobe and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_valid | input | 1 | Seed load strobe, honoured once |
| seed_tod | input | TOD_W | Seed time value from backup clock |
| cfg_max_jump | input | OFS_W | Largest jump a single step may apply |
| cfg_slew_delta | input | INC_W | Largest per-cycle increment bend during slew |
| cfg_min_inc | input | INC_W | Lowest allowed per-cycle increment (0 treated as 1) |
| req_valid | input | 1 | Correction request valid |
| req_ready | output | 1 | Correction request ready |
| req_mode | input | 1 | 1 = step, 0 = slew |
| req_offset | input | OFS_W | Signed correction offset |
| tod_valid | output | 1 | Counter has been seeded |
| tod | output | TOD_W | Current time of day |
| slew_busy | output | 1 | A pending offset is being slewed |
| mark_valid | output | 1 | One-cycle jump marker |
| mark_amount | output | OFS_W | Jump applied with the marker |
| limit_hit | output | 1 | Step was clamped to cfg_max_jump |
| rollback_flag | output | 1 | Request would have moved time backward |
| rollback_cnt | output | RBC_W | Saturating count of backward attempts |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_seq | output | SEQ_W | Sequence number of the latest event |

## Verification
Two functions share one edge when a step is accepted: the nominal advance and the jump both land in a single tod update. A clamped step adds the limit flag and the start of remainder slewing on top of this. The bench provokes the overlap with steps below, at and above the cap. It judges the step by the exact difference in tod across the accepting edge, then by the total advance once slewing ends. Against the elapsed cycle count, that total must equal the nominal growth plus the full requested offset. A second overlap occurs when a backward attempt and the later slew completion each take their own sequence number. The bench judges this from the evt_seq delta.

// File: rtl/tod_gov_pkg.sv
package tod_gov_pkg;
  typedef enum logic {
    CORR_SLEW = 1'b0,
    CORR_STEP = 1'b1
  } corr_mode_e;
endpackage

// File: rtl/tod_step_gate.sv
// Splits an accepted request into an immediate jump and a slewed remainder.
module tod_step_gate
  import tod_gov_pkg::*;
#(
  parameter int OFS_W = 32
) (
  input  logic                    take,
  input  corr_mode_e              mode,
  input  logic signed [OFS_W-1:0] offset,
  input  logic        [OFS_W-1:0] max_jump,
  output logic        [OFS_W-1:0] jump,
  output logic signed [OFS_W-1:0] remainder,
  output logic                    clamped,
  output logic                    backward
);
  logic is_neg, is_pos;

  always_comb begin
    is_neg    = offset[OFS_W-1];
    is_pos    = !is_neg && (offset != '0);
    jump      = '0;
    remainder = '0;
    clamped   = 1'b0;
    backward  = 1'b0;
    if (take) begin
      if (mode == CORR_STEP && is_pos) begin
        if ($unsigned(offset) > max_jump) begin
          jump      = max_jump;
          remainder = offset - $signed(max_jump);
          clamped   = 1'b1;
        end else begin
          jump = $unsigned(offset);
        end
      end else begin
        // slew request, negative step, or zero offset
        remainder = offset;
        backward  = (mode == CORR_STEP) && is_neg;
      end
    end
  end
endmodule

// File: rtl/tod_slew_unit.sv
// Chooses the signed per-cycle increment bend that works off a pending offset.
module tod_slew_unit #(
  parameter int OFS_W   = 32,
  parameter int INC_W   = 16,
  parameter int NOM_INC = 16
) (
  input  logic signed [OFS_W-1:0] pending,
  input  logic        [INC_W-1:0] slew_delta,
  input  logic        [INC_W-1:0] min_inc,
  output logic signed [INC_W:0]   extra,
  output logic                    finish
);
  localparam logic [INC_W-1:0] NOM_V = INC_W'(NOM_INC);

  logic [INC_W-1:0] floor_v, neg_room, lim, mag;
  logic [OFS_W-1:0] mag_p, lim_ext;
  logic             neg;

  always_comb begin
    floor_v  = (min_inc == '0) ? INC_W'(1) : min_inc;
    neg_room = (NOM_V > floor_v) ? NOM_V - floor_v : '0;
    neg      = pending[OFS_W-1];
    mag_p    = neg ? $unsigned(-pending) : $unsigned(pending);
    lim      = (neg && (neg_room < slew_delta)) ? neg_room : slew_delta;
    lim_ext  = OFS_W'(lim);
    mag      = (mag_p < lim_ext) ? mag_p[INC_W-1:0] : lim;
    extra    = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    finish   = (pending != '0) && (mag_p <= lim_ext);
  end
endmodule

// File: rtl/tod_event_seq.sv
// Registered event strobe with an always-incrementing sequence number.
module tod_event_seq #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic             evt_valid,
  output logic [SEQ_W-1:0] evt_seq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_seq   <= '0;
    end else begin
      evt_valid <= hit;
      if (hit) evt_seq <= evt_seq + SEQ_W'(1);
    end
  end
endmodule

// File: rtl/tod_governor.sv
module tod_governor
  import tod_gov_pkg::*;
#(
  parameter int TOD_W   = 48,
  parameter int OFS_W   = 32,
  parameter int INC_W   = 16,
  parameter int NOM_INC = 16,
  parameter int SEQ_W   = 16,
  parameter int RBC_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_valid,
  input  logic [TOD_W-1:0] seed_tod,
  input  logic [OFS_W-1:0] cfg_max_jump,
  input  logic [INC_W-1:0] cfg_slew_delta,
  input  logic [INC_W-1:0] cfg_min_inc,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_mode,
  input  logic [OFS_W-1:0] req_offset,
  output logic             tod_valid,
  output logic [TOD_W-1:0] tod,
  output logic             slew_busy,
  output logic             mark_valid,
  output logic [OFS_W-1:0] mark_amount,
  output logic             limit_hit,
  output logic             rollback_flag,
  output logic [RBC_W-1:0] rollback_cnt,
  output logic             evt_valid,
  output logic [SEQ_W-1:0] evt_seq
);
  localparam logic [TOD_W-1:0] NOM_T = TOD_W'(NOM_INC);

  logic signed [OFS_W-1:0] pending;
  logic                    accept, seed_take;
  logic        [OFS_W-1:0] g_jump;
  logic signed [OFS_W-1:0] g_rem;
  logic                    g_clamp, g_back;
  logic signed [INC_W:0]   s_extra;
  logic                    s_finish, slew_done, evt_hit;
  logic signed [TOD_W:0]   advance;

  assign slew_busy = (pending != '0);
  assign req_ready = tod_valid && !slew_busy;
  assign accept    = req_valid && req_ready;
  assign seed_take = seed_valid && !tod_valid;
  assign slew_done = slew_busy && s_finish;

  tod_step_gate #(.OFS_W(OFS_W)) u_gate (
    .take      (accept),
    .mode      (corr_mode_e'(req_mode)),
    .offset    ($signed(req_offset)),
    .max_jump  (cfg_max_jump),
    .jump      (g_jump),
    .remainder (g_rem),
    .clamped   (g_clamp),
    .backward  (g_back)
  );

  tod_slew_unit #(.OFS_W(OFS_W), .INC_W(INC_W), .NOM_INC(NOM_INC)) u_slew (
    .pending    (pending),
    .slew_delta (cfg_slew_delta),
    .min_inc    (cfg_min_inc),
    .extra      (s_extra),
    .finish     (s_finish)
  );

  // per-cycle advance: nominal + slew bend + step jump (never negative)
  always_comb begin
    advance = $signed({1'b0, NOM_T}) + (TOD_W+1)'(s_extra)
            + $signed({1'b0, TOD_W'(g_jump)});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_valid <= 1'b0;
      tod       <= '0;
      pending   <= '0;
    end else if (seed_take) begin
      tod_valid <= 1'b1;
      tod       <= seed_tod;
    end else if (tod_valid) begin
      tod <= tod + advance[TOD_W-1:0];
      if (accept)         pending <= g_rem;
      else if (slew_busy) pending <= pending - OFS_W'(s_extra);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_valid    <= 1'b0;
      mark_amount   <= '0;
      limit_hit     <= 1'b0;
      rollback_flag <= 1'b0;
      rollback_cnt  <= '0;
    end else begin
      mark_valid    <= accept && (g_jump != '0);
      if (accept && (g_jump != '0)) mark_amount <= g_jump;
      limit_hit     <= g_clamp;
      rollback_flag <= g_back;
      if (g_back && (rollback_cnt != '1)) rollback_cnt <= rollback_cnt + RBC_W'(1);
    end
  end

  assign evt_hit = seed_take || (accept && (g_jump != '0)) || g_back || slew_done;

  tod_event_seq #(.SEQ_W(SEQ_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (evt_hit),
    .evt_valid (evt_valid),
    .evt_seq   (evt_seq)
  );
endmodule

// File: rtl/tod_governor_chk.sv
module tod_governor_chk #(
  parameter int TOD_W = 48,
  parameter int OFS_W = 32,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFS_W-1:0] cfg_max_jump,
  input logic             req_ready,
  input logic             tod_valid,
  input logic [TOD_W-1:0] tod,
  input logic             slew_busy,
  input logic             mark_valid,
  input logic [OFS_W-1:0] mark_amount,
  input logic             limit_hit,
  input logic             rollback_flag,
  input logic             evt_valid,
  input logic [SEQ_W-1:0] evt_seq
);
  p_seeded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tod_valid |=> tod_valid);

  p_never_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_valid && $past(tod_valid)) |-> (tod > $past(tod)));

  p_ready_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (tod_valid && !slew_busy));

  p_jump_capped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_valid |-> (mark_amount <= $past(cfg_max_jump)));

  p_limit_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |-> mark_valid);

  p_back_no_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_flag |-> !mark_valid);

  p_seq_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && $past(rst_n)) |-> (evt_seq == SEQ_W'($past(evt_seq) + SEQ_W'(1))));

  p_seq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && $past(rst_n)) |-> $stable(evt_seq));
endmodule

bind tod_governor tod_governor_chk #(
  .TOD_W(TOD_W), .OFS_W(OFS_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_max_jump  (cfg_max_jump),
  .req_ready     (req_ready),
  .tod_valid     (tod_valid),
  .tod           (tod),
  .slew_busy     (slew_busy),
  .mark_valid    (mark_valid),
  .mark_amount   (mark_amount),
  .limit_hit     (limit_hit),
  .rollback_flag (rollback_flag),
  .evt_valid     (evt_valid),
  .evt_seq       (evt_seq)
);

// File: tb/tb_tod_governor.sv
module tb_tod_governor;
  localparam int NOM = 16;
  localparam int NV  = 7;
  // vectors: step?, offset, expected jump, expected limit flag, expected rollback flag
  localparam bit VSTEP[NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int VOFS[NV]  = '{40, 100, 250, 30, -21, -24, 0};
  localparam int VJMP[NV]  = '{40, 100, 100, 0, 0, 0, 0};
  localparam bit VLIM[NV]  = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam bit VRB[NV]   = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n, seed_valid, req_valid, req_mode;
  logic [47:0] seed_tod;
  logic [31:0] cfg_max_jump, req_offset;
  logic [15:0] cfg_slew_delta, cfg_min_inc;
  logic        req_ready, tod_valid, slew_busy, mark_valid, limit_hit, rollback_flag, evt_valid;
  logic [47:0] tod;
  logic [31:0] mark_amount;
  logic [7:0]  rollback_cnt;
  logic [15:0] evt_seq;

  int checks = 0, failures = 0, mono_bad = 0;

  always #5 clk = ~clk;

  tod_governor dut (
    .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid), .seed_tod(seed_tod),
    .cfg_max_jump(cfg_max_jump), .cfg_slew_delta(cfg_slew_delta), .cfg_min_inc(cfg_min_inc),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode), .req_offset(req_offset),
    .tod_valid(tod_valid), .tod(tod), .slew_busy(slew_busy), .mark_valid(mark_valid),
    .mark_amount(mark_amount), .limit_hit(limit_hit), .rollback_flag(rollback_flag),
    .rollback_cnt(rollback_cnt), .evt_valid(evt_valid), .evt_seq(evt_seq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // R3 monitor: once seeded, each cycle adds at least the floor (4)
  logic [47:0] prev_tod;
  bit          prev_ok = 1'b0;
  always @(negedge clk) begin
    if (rst_n && tod_valid && prev_ok && (tod < prev_tod + 48'd4)) begin
      mono_bad++;
      $display("FAIL R3 monotonic step actual=%0d expected>=%0d", tod, prev_tod + 48'd4);
    end
    prev_tod = tod;
    prev_ok  = rst_n && tod_valid;
  end

  task automatic run_vec(input int i);
    longint      t0;
    logic [15:0] s0, exp_ev;
    int          n;
    @(negedge clk);
    chk(req_ready == 1'b1, "R4 ready when idle", req_ready, 1);
    t0 = longint'(tod);
    s0 = evt_seq;
    req_valid  = 1'b1;
    req_mode   = VSTEP[i];
    req_offset = VOFS[i];
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk(longint'(tod) - t0 == NOM + VJMP[i], "R5 advance on accepting edge",
        longint'(tod) - t0, NOM + VJMP[i]);
    chk(mark_valid == (VJMP[i] != 0), "R5 marker strobe", mark_valid, VJMP[i] != 0);
    if (VJMP[i] != 0)
      chk(mark_amount == VJMP[i], "R5 marker amount", mark_amount, VJMP[i]);
    chk(limit_hit == VLIM[i], "R6 limit flag", limit_hit, VLIM[i]);
    chk(rollback_flag == VRB[i], "R8 rollback flag", rollback_flag, VRB[i]);
    if (VOFS[i] == 0)
      chk(!evt_valid && !slew_busy, "R10 zero offset inert", evt_valid, 0);
    while (slew_busy) begin
      if (req_ready) begin
        failures++;
        $display("FAIL R4 ready while slewing actual=1 expected=0");
      end
      @(negedge clk);
      n++;
    end
    chk(longint'(tod) - t0 == longint'(n) * NOM + VOFS[i], "R7 total advance after slew",
        longint'(tod) - t0, longint'(n) * NOM + VOFS[i]);
    exp_ev = 16'(VJMP[i] != 0) + 16'(VRB[i]) + 16'((VOFS[i] - VJMP[i]) != 0);
    chk(16'(evt_seq - s0) == exp_ev, "R9 sequence delta", 16'(evt_seq - s0), exp_ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    longint t0, d;
    int     k;
    rst_n = 1'b0; seed_valid = 1'b0; seed_tod = '0; req_valid = 1'b0;
    req_mode = 1'b0; req_offset = '0;
    cfg_max_jump = 32'd100; cfg_slew_delta = 16'd3; cfg_min_inc = 16'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tod == 0 && !tod_valid, "R1 tod cleared", tod, 0);
    chk(!req_ready && evt_seq == 0, "R1 ready low and seq zero", evt_seq, 0);
    chk(!mark_valid && !limit_hit && !rollback_flag && !evt_valid, "R1 strobes low", mark_valid, 0);

    // R2 seed
    seed_valid = 1'b1; seed_tod = 48'd1000;
    @(negedge clk);
    seed_valid = 1'b0;
    chk(tod == 1000 && tod_valid, "R2 seed loaded", tod, 1000);
    chk(evt_valid && evt_seq == 1, "R9 seed event", evt_seq, 1);
    @(negedge clk);
    chk(tod == 1000 + NOM, "R2 nominal advance", tod, 1000 + NOM);
    t0 = longint'(tod);
    seed_valid = 1'b1; seed_tod = 48'd5;
    @(negedge clk);
    seed_valid = 1'b0;
    chk(longint'(tod) == t0 + NOM, "R2 later seed ignored", tod, t0 + NOM);

    // vector table
    for (int i = 0; i < NV; i++) run_vec(i);
    chk(rollback_cnt == 1, "R8 rollback counter", rollback_cnt, 1);

    // R3 floor on negative slew: delta 20 limited to NOM-4=12
    cfg_slew_delta = 16'd20;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 1'b0; req_offset = -32'sd30;
    @(negedge clk);
    req_valid = 1'b0;
    t0 = longint'(tod);
    @(negedge clk);
    d = longint'(tod) - t0; t0 = longint'(tod);
    chk(d == 4, "R3 floored increment 1", d, 4);
    @(negedge clk);
    d = longint'(tod) - t0; t0 = longint'(tod);
    chk(d == 4, "R3 floored increment 2", d, 4);
    @(negedge clk);
    d = longint'(tod) - t0;
    chk(d == 10, "R7 final partial slew", d, 10);
    chk(!slew_busy, "R7 slew drained", slew_busy, 0);
    cfg_slew_delta = 16'd3;

    // R4 back-pressure: step held valid behind a slew of 30 (10 cycles)
    @(negedge clk);
    t0 = longint'(tod);
    req_valid = 1'b1; req_mode = 1'b0; req_offset = 32'd30;
    @(negedge clk);
    req_mode = 1'b1; req_offset = 32'd10;
    k = 1;
    while (!mark_valid && k < 40) begin
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    chk(k == 12, "R4 held request taken when ready rises", k, 12);
    chk(longint'(tod) - t0 == 12 * NOM + 40, "R4 both corrections applied",
        longint'(tod) - t0, 12 * NOM + 40);

    repeat (2) @(negedge clk);
    chk(mono_bad == 0, "R3 monotonic monitor", mono_bad, 0);
    finish_run();
  end
endmodule